// File: doc/BRIEF.md
# Decoded Micro-Op Window Cache

This block keeps micro-operations that have already been decoded, so that a repeated fetch of the same code can bypass the decoders. The unit of storage is a 32-byte aligned code window. When the decode path finishes a window, it presents every micro-op of that window in one cycle on the fill port. The cache either places the window whole, across one to three lines of a single set, or refuses it entirely. Micro-ops are opaque fixed-width payloads.

On the lookup side, a fetch address is offered with a valid/ready handshake. If every line of the matching window is resident, the block replays the window to the back end in fill order, at most four micro-ops per beat, under a valid/ready handshake. Otherwise it raises a one-cycle miss indication, and the fetch unit falls back to the decoders. A flush input invalidates the whole array in one cycle. Victim lines are chosen by a per-set tree pseudo-LRU, and a window that loses any line loses all of them.

Top module: `uop_window_cache`

## Requirements
- R1: After reset, and in every cycle following a flush, all lookups miss. A lookup accepted in the same cycle as a flush also reports a miss.
- R2: A window filled with n micro-ops (1 <= n <= 18) hits on lookup. It is delivered in fill order over ceil(n/4) beats. Beat b carries out_count = min(4, n-4b), with micro-op 4b+l in lane l at bits [l*UOP_W +: UOP_W]. out_last is set only on the final beat.
- R3: A fill whose count is 0 or greater than 18 stores nothing. The refused window misses, and windows already in the set keep hitting with their own data.
- R4: The set is addr[9:5] and the tag is addr[31:10]. Address bits [4:0] are ignored, and a lookup with the same set but a different tag misses.
- R5: Refilling a resident window replaces its contents, and the next hit delivers the new micro-ops and count.
- R6: Each set has a tree pseudo-LRU that is updated by fills and by hits. Suppose eight one-line windows are filled in order into an empty set. A ninth fill then evicts the first of them. If the first was hit before the ninth fill, the fifth is evicted instead.
- R7: When a victim line belongs to a multi-line window, every line of that window is invalidated together, so the window misses rather than returning part of its data. Freed lines are reused by later fills without further eviction.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_count, out_last and out_uops hold.
- R9: lkp_ready is low while a window is being delivered. A miss pulse appears in exactly the cycle after an accepted lookup that misses, and the first beat appears in the cycle after an accepted lookup that hits.
- R10: A flush during delivery ends it: out_valid is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush_i | input | 1 | Invalidate every line |
| fill_valid_i | input | 1 | Fill request |
| fill_addr_i | input | ADDR_W | Any address inside the window being filled |
| fill_count_i | input | FCNT_W | Number of micro-ops decoded from the window |
| fill_uops_i | input | 18*UOP_W | Micro-ops, micro-op k at [k*UOP_W +: UOP_W] |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_addr_i | input | ADDR_W | Fetch address |
| lkp_ready_o | output | 1 | Lookup accepted when high |
| miss_o | output | 1 | One-cycle miss indication |
| out_valid_o | output | 1 | Delivery beat valid |
| out_ready_i | input | 1 | Back end accepts the beat |
| out_count_o | output | 3 | Micro-ops in this beat |
| out_uops_o | output | 4*UOP_W | Beat lanes |
| out_last_o | output | 1 | Final beat of the window |

## Verification
The bench sweeps every legal window size from 1 to 18 micro-ops. This exposes any error in line splitting, beat counts or the final-beat marker; such a design would drop or repeat micro-ops, or mark the wrong beat as last. Every illegal count from 0 and 19 to 31 is pushed into a set that already holds a window. A design that stored part of an oversize window, or disturbed its neighbour, would show a spurious hit or corrupt data. Eviction order is checked both with and without an intervening hit. A multi-line window is deliberately made the victim, to catch a design that frees only one of its lines and then returns a partial window. Stalls and flushes in the middle of delivery target payload drift and a stream that survives a flush.

// File: rtl/uopc_pkg.sv
package uopc_pkg;

  localparam int PLRU_MAXW = 64;
  typedef logic [PLRU_MAXW-1:0] plru_t;

  typedef enum logic {ST_IDLE, ST_BUSY} strm_st_e;

  // Tree node i (heap order, root = 1) lives at bit i-1; 0 steers left.
  function automatic plru_t plru_touch(plru_t t, int way, int lvl);
    plru_t r;
    int    node;
    int    b;
    r    = t;
    node = 1;
    for (int l = lvl - 1; l >= 0; l--) begin
      b           = (way >> l) & 1;
      r[node - 1] = (b == 0);
      node        = node * 2 + b;
    end
    return r;
  endfunction

  function automatic int plru_victim(plru_t t, int lvl);
    int node;
    node = 1;
    for (int l = 0; l < lvl; l++) begin
      node = node * 2 + (t[node - 1] ? 1 : 0);
    end
    return node - (1 << lvl);
  endfunction

endpackage

// File: rtl/uopc_plru_upd.sv
module uopc_plru_upd
  import uopc_pkg::*;
#(
  parameter int WAYS = 8
) (
  input  logic [WAYS-2:0] tree_i,
  input  logic [WAYS-1:0] touch_i,
  output logic [WAYS-2:0] tree_o
);
  localparam int LVL = $clog2(WAYS);

  plru_t t;

  always_comb begin
    t = plru_t'(tree_i);
    for (int w = 0; w < WAYS; w++) begin
      if (touch_i[w]) t = plru_touch(t, w, LVL);
    end
    tree_o = t[WAYS-2:0];
  end

endmodule

// File: rtl/uopc_match.sv
module uopc_match #(
  parameter int WAYS      = 8,
  parameter int TAG_W     = 22,
  parameter int SEQ_W     = 2,
  parameter int NL_W      = 2,
  parameter int MAX_LINES = 3,
  parameter int WAY_W     = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]                 valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]      tag_i,
  input  logic [WAYS-1:0][SEQ_W-1:0]      seq_i,
  input  logic [WAYS-1:0][NL_W-1:0]       nl_i,
  input  logic [TAG_W-1:0]                key_i,
  output logic                            hit_o,
  output logic [WAYS-1:0]                 match_o,
  output logic [MAX_LINES-1:0][WAY_W-1:0] sel_o,
  output logic [NL_W-1:0]                 nl_o
);
  int   pc;
  logic head;

  always_comb begin
    pc    = 0;
    head  = 1'b0;
    nl_o  = '0;
    sel_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      match_o[w] = valid_i[w] && (tag_i[w] == key_i);
    end
    for (int w = 0; w < WAYS; w++) begin
      if (match_o[w]) begin
        pc = pc + 1;
        if (seq_i[w] == '0) begin
          head = 1'b1;
          nl_o = nl_i[w];
        end
        for (int s = 0; s < MAX_LINES; s++) begin
          if (int'(seq_i[w]) == s) sel_o[s] = WAY_W'(w);
        end
      end
    end
    // every line of the window must be resident
    hit_o = head && (pc == int'(nl_o));
  end

endmodule

// File: rtl/uopc_alloc.sv
module uopc_alloc
  import uopc_pkg::*;
#(
  parameter int WAYS      = 8,
  parameter int TAG_W     = 22,
  parameter int NL_W      = 2,
  parameter int MAX_LINES = 3,
  parameter int WAY_W     = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]                 valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]      tag_i,
  input  logic [WAYS-2:0]                 plru_i,
  input  logic [TAG_W-1:0]                key_i,
  input  logic [NL_W-1:0]                 need_i,
  output logic [WAYS-1:0]                 kill_o,
  output logic [WAYS-1:0]                 alloc_o,
  output logic [MAX_LINES-1:0][WAY_W-1:0] sel_o
);
  localparam int LVL = $clog2(WAYS);

  plru_t           p;
  logic [WAYS-1:0] fr;
  int              v;
  int              k2;

  always_comb begin
    p      = plru_t'(plru_i);
    kill_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_i[w] && tag_i[w] == key_i) kill_o[w] = 1'b1;
    end
    fr = ~valid_i | kill_o;
    // evict whole windows in pseudo-LRU order until enough lines are free
    for (int k = 0; k < MAX_LINES; k++) begin
      v = 0;
      if ($countones(fr) < int'(need_i)) begin
        v = plru_victim(p, LVL);
        if (valid_i[v]) begin
          for (int w = 0; w < WAYS; w++) begin
            if (valid_i[w] && tag_i[w] == tag_i[v]) kill_o[w] = 1'b1;
          end
        end
        fr = ~valid_i | kill_o;
        p  = plru_touch(p, v, LVL);
      end
    end
    alloc_o = '0;
    sel_o   = '0;
    k2      = 0;
    for (int w = 0; w < WAYS; w++) begin
      if (fr[w] && k2 < int'(need_i)) begin
        alloc_o[w] = 1'b1;
        sel_o[k2]  = WAY_W'(w);
        k2         = k2 + 1;
      end
    end
  end

endmodule

// File: rtl/uopc_stream.sv
module uopc_stream
  import uopc_pkg::*;
#(
  parameter int UOP_W   = 16,
  parameter int WIN_MAX = 18,
  parameter int OUT_MAX = 4,
  parameter int TOT_W   = $clog2(WIN_MAX + 1),
  parameter int OC_W    = $clog2(OUT_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush_i,
  input  logic                     load_i,
  input  logic [WIN_MAX*UOP_W-1:0] buf_i,
  input  logic [TOT_W-1:0]         total_i,
  input  logic                     ready_i,
  output logic                     valid_o,
  output logic [OC_W-1:0]          count_o,
  output logic [OUT_MAX*UOP_W-1:0] uops_o,
  output logic                     last_o
);
  localparam int EXT_W = (WIN_MAX + OUT_MAX) * UOP_W;

  strm_st_e                 st_q, st_d;
  logic [TOT_W-1:0]         ptr_q, ptr_d, tot_q, rem;
  logic [WIN_MAX*UOP_W-1:0] buf_q;
  logic [EXT_W-1:0]         sh;
  logic                     ld;

  always_comb begin
    rem     = tot_q - ptr_q;
    last_o  = rem <= TOT_W'(OUT_MAX);
    count_o = last_o ? OC_W'(rem) : OC_W'(OUT_MAX);
    valid_o = (st_q == ST_BUSY);
    sh      = {{(OUT_MAX*UOP_W){1'b0}}, buf_q} >> (int'(ptr_q) * UOP_W);
    uops_o  = sh[OUT_MAX*UOP_W-1:0];
  end

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    ld    = 1'b0;
    if (flush_i) begin
      st_d = ST_IDLE;
    end else if (load_i) begin
      st_d  = ST_BUSY;
      ptr_d = '0;
      ld    = 1'b1;
    end else if (valid_o && ready_i) begin
      if (last_o) st_d = ST_IDLE;
      else        ptr_d = ptr_q + TOT_W'(OUT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      buf_q <= buf_i;
      tot_q <= total_i;
    end
  end

endmodule

// File: rtl/uop_window_cache.sv
module uop_window_cache
  import uopc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int UOP_W     = 16,
  parameter int SETS      = 32,
  parameter int WAYS      = 8,
  parameter int LINE_UOPS = 6,
  parameter int MAX_LINES = 3,
  parameter int WIN_BYTES = 32,
  parameter int OUT_MAX   = 4,
  parameter int FCNT_W    = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 flush_i,
  input  logic                                 fill_valid_i,
  input  logic [ADDR_W-1:0]                    fill_addr_i,
  input  logic [FCNT_W-1:0]                    fill_count_i,
  input  logic [MAX_LINES*LINE_UOPS*UOP_W-1:0] fill_uops_i,
  input  logic                                 lkp_valid_i,
  input  logic [ADDR_W-1:0]                    lkp_addr_i,
  output logic                                 lkp_ready_o,
  output logic                                 miss_o,
  output logic                                 out_valid_o,
  input  logic                                 out_ready_i,
  output logic [$clog2(OUT_MAX+1)-1:0]         out_count_o,
  output logic [OUT_MAX*UOP_W-1:0]             out_uops_o,
  output logic                                 out_last_o
);
  localparam int OFS_W   = $clog2(WIN_BYTES);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - IDX_W - OFS_W;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int WIN_MAX = MAX_LINES * LINE_UOPS;
  localparam int LINE_W  = LINE_UOPS * UOP_W;
  localparam int SEQ_W   = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1;
  localparam int NL_W    = $clog2(MAX_LINES + 1);
  localparam int LC_W    = $clog2(LINE_UOPS + 1);
  localparam int TOT_W   = $clog2(WIN_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // storage
  logic [SETS-1:0][WAYS-1:0]            valid_q, valid_d;
  logic [SETS-1:0][WAYS-2:0]            plru_q, plru_d;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0][SEQ_W-1:0] seq_q;
  logic [SETS-1:0][WAYS-1:0][NL_W-1:0]  nl_q;
  logic [SETS-1:0][WAYS-1:0][LC_W-1:0]  cnt_q;
  logic [LINE_W-1:0]                    data_q [SETS][WAYS];
  logic                                 miss_q;

  logic unused_lo;
  assign unused_lo = ^{lkp_addr_i[OFS_W-1:0], fill_addr_i[OFS_W-1:0]};

  // lookup path
  logic [IDX_W-1:0]                 l_idx;
  logic [TAG_W-1:0]                 l_tag;
  logic                             m_hit, accept, hit_now;
  logic [WAYS-1:0]                  m_match;
  logic [MAX_LINES-1:0][WAY_W-1:0]  m_sel;
  logic [NL_W-1:0]                  m_nl;
  logic [WIN_MAX*UOP_W-1:0]         l_buf;
  logic [TOT_W-1:0]                 l_tot;
  logic [WAYS-2:0]                  l_plru;

  assign l_idx = lkp_addr_i[OFS_W +: IDX_W];
  assign l_tag = lkp_addr_i[ADDR_W-1 -: TAG_W];

  uopc_match #(.WAYS(WAYS), .TAG_W(TAG_W), .SEQ_W(SEQ_W), .NL_W(NL_W),
               .MAX_LINES(MAX_LINES)) match_i (
    .valid_i(valid_q[l_idx]), .tag_i(tag_q[l_idx]), .seq_i(seq_q[l_idx]),
    .nl_i(nl_q[l_idx]), .key_i(l_tag), .hit_o(m_hit), .match_o(m_match),
    .sel_o(m_sel), .nl_o(m_nl)
  );

  assign accept  = lkp_valid_i && lkp_ready_o;
  assign hit_now = accept && m_hit && !flush_i;

  always_comb begin
    l_tot = '0;
    for (int s = 0; s < MAX_LINES; s++) begin
      l_buf[s*LINE_W +: LINE_W] = data_q[l_idx][m_sel[s]];
      if (s < int'(m_nl)) l_tot = l_tot + TOT_W'(cnt_q[l_idx][m_sel[s]]);
    end
  end

  uopc_plru_upd #(.WAYS(WAYS)) hit_upd_i (
    .tree_i(plru_q[l_idx]), .touch_i(m_match & {WAYS{m_hit}}), .tree_o(l_plru)
  );

  // fill path
  logic [IDX_W-1:0]                 f_idx;
  logic [TAG_W-1:0]                 f_tag;
  logic                             f_ok;
  logic [NL_W-1:0]                  f_need;
  logic [WAYS-1:0]                  f_kill, f_alloc;
  logic [MAX_LINES-1:0][WAY_W-1:0]  f_sel;
  logic [MAX_LINES-1:0][LC_W-1:0]   f_lc;
  logic [WAYS-2:0]                  f_plru;
  int                               f_rem;

  assign f_idx  = fill_addr_i[OFS_W +: IDX_W];
  assign f_tag  = fill_addr_i[ADDR_W-1 -: TAG_W];
  assign f_ok   = fill_valid_i && !flush_i && (fill_count_i != '0) &&
                  (int'(fill_count_i) <= WIN_MAX);
  assign f_need = NL_W'((int'(fill_count_i) + LINE_UOPS - 1) / LINE_UOPS);

  always_comb begin
    for (int s = 0; s < MAX_LINES; s++) begin
      f_rem   = int'(fill_count_i) - s * LINE_UOPS;
      f_lc[s] = (f_rem >= LINE_UOPS) ? LC_W'(LINE_UOPS) : LC_W'(f_rem);
    end
  end

  uopc_alloc #(.WAYS(WAYS), .TAG_W(TAG_W), .NL_W(NL_W),
               .MAX_LINES(MAX_LINES)) alloc_i (
    .valid_i(valid_q[f_idx]), .tag_i(tag_q[f_idx]), .plru_i(plru_q[f_idx]),
    .key_i(f_tag), .need_i(f_need), .kill_o(f_kill), .alloc_o(f_alloc),
    .sel_o(f_sel)
  );

  uopc_plru_upd #(.WAYS(WAYS)) fill_upd_i (
    .tree_i(plru_q[f_idx]), .touch_i(f_alloc), .tree_o(f_plru)
  );

  // next state
  always_comb begin
    valid_d = valid_q;
    plru_d  = plru_q;
    if (hit_now) plru_d[l_idx] = l_plru;
    if (flush_i) begin
      valid_d = '0;
    end else if (f_ok) begin
      valid_d[f_idx] = (valid_q[f_idx] & ~f_kill) | f_alloc;
      plru_d[f_idx]  = f_plru;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= '0;
      plru_q  <= '0;
      miss_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      plru_q  <= plru_d;
      miss_q  <= accept && !hit_now;
    end
  end

  always_ff @(posedge clk) begin
    if (f_ok) begin
      for (int s = 0; s < MAX_LINES; s++) begin
        if (s < int'(f_need)) begin
          tag_q[f_idx][f_sel[s]]  <= f_tag;
          seq_q[f_idx][f_sel[s]]  <= SEQ_W'(s);
          nl_q[f_idx][f_sel[s]]   <= f_need;
          cnt_q[f_idx][f_sel[s]]  <= f_lc[s];
          data_q[f_idx][f_sel[s]] <= fill_uops_i[s*LINE_W +: LINE_W];
        end
      end
    end
  end

  // delivery
  uopc_stream #(.UOP_W(UOP_W), .WIN_MAX(WIN_MAX), .OUT_MAX(OUT_MAX)) stream_i (
    .clk(clk), .rst_n(rst_int_n), .flush_i(flush_i), .load_i(hit_now),
    .buf_i(l_buf), .total_i(l_tot), .ready_i(out_ready_i),
    .valid_o(out_valid_o), .count_o(out_count_o), .uops_o(out_uops_o),
    .last_o(out_last_o)
  );

  assign lkp_ready_o = !out_valid_o;
  assign miss_o      = miss_q;

endmodule

// File: rtl/uopc_checker.sv
module uopc_checker #(
  parameter int UOP_W   = 16,
  parameter int OUT_MAX = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         flush_i,
  input logic                         lkp_valid_i,
  input logic                         lkp_ready_o,
  input logic                         miss_o,
  input logic                         out_valid_o,
  input logic                         out_ready_i,
  input logic [$clog2(OUT_MAX+1)-1:0] out_count_o,
  input logic [OUT_MAX*UOP_W-1:0]     out_uops_o,
  input logic                         out_last_o
);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i && !flush_i |=>
      out_valid_o && $stable(out_uops_o) && $stable(out_count_o) && $stable(out_last_o));

  assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_count_o != '0) && (int'(out_count_o) <= OUT_MAX));

  assert_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_ready_i && out_last_o && !flush_i |=> !out_valid_o);

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !lkp_ready_o);

  assert_miss_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> $past(lkp_valid_i && lkp_ready_o) && !out_valid_o);

  assert_flush_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !out_valid_o);

  assert_flush_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i && lkp_valid_i && lkp_ready_o |=> miss_o);

endmodule

bind uop_window_cache uopc_checker #(.UOP_W(UOP_W), .OUT_MAX(OUT_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .lkp_valid_i(lkp_valid_i),
  .lkp_ready_o(lkp_ready_o), .miss_o(miss_o), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .out_count_o(out_count_o),
  .out_uops_o(out_uops_o), .out_last_o(out_last_o)
);

// File: tb/uop_window_cache_tb_top.sv
`timescale 1ns/1ps
module uop_window_cache_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush_i = 1'b0;
  logic         fill_valid_i = 1'b0;
  logic [31:0]  fill_addr_i = '0;
  logic [4:0]   fill_count_i = '0;
  logic [287:0] fill_uops_i = '0;
  logic         lkp_valid_i = 1'b0;
  logic [31:0]  lkp_addr_i = '0;
  logic         lkp_ready_o, miss_o, out_valid_o, out_last_o;
  logic         out_ready_i = 1'b1;
  logic [2:0]   out_count_o;
  logic [63:0]  out_uops_o;

  int vecs = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  uop_window_cache dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .fill_valid_i(fill_valid_i),
    .fill_addr_i(fill_addr_i), .fill_count_i(fill_count_i),
    .fill_uops_i(fill_uops_i), .lkp_valid_i(lkp_valid_i),
    .lkp_addr_i(lkp_addr_i), .lkp_ready_o(lkp_ready_o), .miss_o(miss_o),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_count_o(out_count_o), .out_uops_o(out_uops_o), .out_last_o(out_last_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      fails = fails + 1;
      $display("FAIL R9 watchdog act=%0d exp=<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mk_addr(int tag, int set, int off);
    return {tag[21:0], set[4:0], off[4:0]};
  endfunction

  function automatic logic [15:0] uop(int seed, int k);
    return {seed[7:0], k[7:0]};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vecs = vecs + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] a, input int n, input int seed);
    fill_addr_i  = a;
    fill_count_i = n[4:0];
    for (int k = 0; k < 18; k++) fill_uops_i[k*16 +: 16] = (k < n) ? uop(seed, k) : 16'hDEAD;
    fill_valid_i = 1'b1;
    @(negedge clk);
    fill_valid_i = 1'b0;
  endtask

  task automatic stream(input int n, input int seed, input int stall_beat, input string rq);
    int beats;
    int ec;
    logic [63:0] snap;
    beats = (n + 3) / 4;
    for (int b = 0; b < beats; b++) begin
      ec = (n - 4*b > 4) ? 4 : n - 4*b;
      check(out_valid_o == 1'b1, rq, "beat valid", 64'(out_valid_o), 64'd1);
      check(out_count_o == ec[2:0], rq, "beat count", 64'(out_count_o), 64'(ec));
      check(out_last_o == (b == beats-1), rq, "last flag", 64'(out_last_o), 64'(b == beats-1));
      for (int l = 0; l < ec; l++)
        check(out_uops_o[l*16 +: 16] == uop(seed, 4*b+l), rq, "lane data",
              64'(out_uops_o[l*16 +: 16]), 64'(uop(seed, 4*b+l)));
      if (b == stall_beat) begin
        snap = out_uops_o;
        out_ready_i = 1'b0;
        repeat (3) begin
          @(negedge clk);
          check(out_valid_o && out_uops_o == snap && out_count_o == ec[2:0],
                "R8", "hold under stall", out_uops_o, snap);
          check(!lkp_ready_o, "R9", "ready low while busy", 64'(lkp_ready_o), 64'd0);
        end
        out_ready_i = 1'b1;
      end
      @(negedge clk);
    end
    check(out_valid_o == 1'b0, rq, "idle after last", 64'(out_valid_o), 64'd0);
  endtask

  task automatic lookup(input logic [31:0] a, input bit exp_hit, input int n,
                        input int seed, input int stall_beat, input string rq);
    int g;
    g = 0;
    while (!lkp_ready_o && g < 50) begin @(negedge clk); g++; end
    lkp_addr_i  = a;
    lkp_valid_i = 1'b1;
    @(negedge clk);
    lkp_valid_i = 1'b0;
    if (!exp_hit) begin
      check(miss_o && !out_valid_o, rq, "miss", {62'd0, miss_o, out_valid_o}, 64'h2);
      @(negedge clk);
    end else begin
      check(!miss_o, rq, "no miss on hit", 64'(miss_o), 64'd0);
      stream(n, seed, stall_beat, rq);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(lkp_ready_o && !out_valid_o && !miss_o, "R1", "reset outputs",
          {61'd0, lkp_ready_o, out_valid_o, miss_o}, 64'h4);
    lookup(mk_addr(7, 1, 0), 1'b0, 0, 0, -1, "R1");

    // R2/R4: every legal size, lookup at another byte offset of the window
    for (int n = 1; n <= 18; n++) begin
      fill(mk_addr(n + 50, n, (n*3) % 32), n, n);
      lookup(mk_addr(n + 50, n, (n*7) % 32), 1'b1, n, n, -1, "R2");
    end
    // R4: same set, other tag
    lookup(mk_addr(99, 5, 0), 1'b0, 0, 0, -1, "R4");
    lookup(mk_addr(55, 5, 31), 1'b1, 5, 5, -1, "R4");

    // R5: refill replaces contents
    fill(mk_addr(57, 7, 0), 11, 8'hA7);
    lookup(mk_addr(57, 7, 4), 1'b1, 11, 8'hA7, -1, "R5");
    fill(mk_addr(57, 7, 0), 3, 8'hB3);
    lookup(mk_addr(57, 7, 9), 1'b1, 3, 8'hB3, -1, "R5");

    // R3: refused counts leave the set unchanged
    fill(mk_addr(9, 25, 0), 5, 8'h55);
    for (int n = 0; n <= 31; n++) begin
      if (n == 0 || n > 18) begin
        fill(mk_addr(10, 25, 0), n, 8'h60);
        lookup(mk_addr(10, 25, 0), 1'b0, 0, 0, -1, "R3");
        lookup(mk_addr(9, 25, 0), 1'b1, 5, 8'h55, -1, "R3");
      end
    end

    // R8: stall in the middle of delivery
    lookup(mk_addr(63, 13, 0), 1'b1, 13, 13, 1, "R8");

    // R10: flush while delivering
    lookup(mk_addr(68, 18, 0), 1'b1, 18, 18, -1, "R2");
    lkp_addr_i  = mk_addr(68, 18, 0);
    lkp_valid_i = 1'b1;
    @(negedge clk);
    lkp_valid_i = 1'b0;
    check(out_valid_o, "R10", "stream started", 64'(out_valid_o), 64'd1);
    out_ready_i = 1'b0;
    flush_i     = 1'b1;
    @(negedge clk);
    flush_i     = 1'b0;
    out_ready_i = 1'b1;
    check(!out_valid_o, "R10", "stream aborted", 64'(out_valid_o), 64'd0);

    // R1: everything gone after flush
    lookup(mk_addr(68, 18, 0), 1'b0, 0, 0, -1, "R1");
    lookup(mk_addr(52, 2, 0), 1'b0, 0, 0, -1, "R1");

    // R1: lookup in the flush cycle misses
    fill(mk_addr(70, 20, 0), 4, 8'h70);
    lkp_addr_i  = mk_addr(70, 20, 0);
    lkp_valid_i = 1'b1;
    flush_i     = 1'b1;
    @(negedge clk);
    lkp_valid_i = 1'b0;
    flush_i     = 1'b0;
    check(miss_o && !out_valid_o, "R1", "flush-cycle lookup", 64'(miss_o), 64'd1);
    @(negedge clk);

    // R6: eight one-line windows, ninth evicts the first
    for (int t = 0; t < 8; t++) fill(mk_addr(100 + t, 3, 0), 2, 8'h30 + t);
    fill(mk_addr(108, 3, 0), 2, 8'h38);
    lookup(mk_addr(100, 3, 0), 1'b0, 0, 0, -1, "R6");
    for (int t = 1; t < 9; t++) lookup(mk_addr(100 + t, 3, 0), 1'b1, 2, 8'h30 + t, -1, "R6");

    // R6: a hit on the first moves the victim to the fifth
    for (int t = 0; t < 8; t++) fill(mk_addr(200 + t, 4, 0), 1, 8'h40 + t);
    lookup(mk_addr(200, 4, 0), 1'b1, 1, 8'h40, -1, "R6");
    fill(mk_addr(208, 4, 0), 1, 8'h48);
    lookup(mk_addr(204, 4, 0), 1'b0, 0, 0, -1, "R6");
    lookup(mk_addr(200, 4, 0), 1'b1, 1, 8'h40, -1, "R6");
    lookup(mk_addr(208, 4, 0), 1'b1, 1, 8'h48, -1, "R6");

    // R7: evicting a three-line window frees all its lines
    fill(mk_addr(300, 6, 0), 15, 8'h61);
    for (int t = 0; t < 5; t++) fill(mk_addr(310 + t, 6, 0), 3, 8'h70 + t);
    fill(mk_addr(320, 6, 0), 6, 8'h80);
    lookup(mk_addr(300, 6, 0), 1'b0, 0, 0, -1, "R7");
    lookup(mk_addr(320, 6, 0), 1'b1, 6, 8'h80, -1, "R7");
    fill(mk_addr(330, 6, 0), 8, 8'h90);
    lookup(mk_addr(330, 6, 0), 1'b1, 8, 8'h90, -1, "R7");
    lookup(mk_addr(320, 6, 0), 1'b1, 6, 8'h80, -1, "R7");
    for (int t = 0; t < 5; t++) lookup(mk_addr(310 + t, 6, 0), 1'b1, 3, 8'h70 + t, -1, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule